// File: doc/BRIEF.md
# Keyed Power and Clock Control Register Block

This block holds the power-state and core-clock settings of a small microcontroller as two bus-visible registers. The power register carries four domain enables (crystal, PLL, peripheral and core) and a 3-bit core clock divide select. The peripheral register carries separate enables for the SPI/I2C, UART and PWM units. The block drives all of these as steady control levels. It does not contain any oscillator, PLL or divider. It only tells them what to do.

Neither register can be changed by a plain bus write. A change has to be wrapped in a keyed sequence of three writes: an unlock key write, the write of the new value, then a commit key write. Each of the three must directly follow the one before it, with no other bus write in between. Reads between them do not matter. If the sequence is broken or a key is wrong, the pending value is dropped.

When a power value is committed, the block applies the shutdown ordering rules. It puts back to 1 any enable whose power-down would be illegal. A wake-up event turns the PLL, peripheral and core domains back on.

Top module: `pwr_key_regs`

## Requirements
- R1: After reset the power register (address 0x0) reads 0x7B and the peripheral register (address 0x3) reads 0x124. All enable outputs are 1 and the divide select output is 3'b011. The divide select field value n stands for a core clock of 10.24 MHz / 2^n.
- R2: A write to address 0x0 takes effect only in this case: the write just before it put 0x01 into key address 0x1, and the write just after it puts 0xF4 into key address 0x2. The register keeps its old value until that last key write, and it updates at the clock edge of that write.
- R3: A write to address 0x0 that is not preceded by the 0x01 key write has no effect.
- R4: The pending value is discarded in three cases: the commit key carries the wrong value; another bus write comes between the unlock key and the protected write; another bus write comes between the protected write and the commit key.
- R5: A write to address 0x3 takes effect only when 0x76 was written to address 0x4 directly before it and 0xB1 is written to address 0x5 directly after it.
- R6: Bit 7 of the power register always reads 0, whatever value is written.
- R7: Power register bits: bit 6 is crystal enable, bit 5 is PLL enable, bit 4 is peripheral enable, bit 3 is core enable, and bits 2:0 are the divide select. A 0 powers a domain down. Clearing bit 5 is accepted only if bits 5, 4 and 3 are all 0 in the same write. Otherwise bit 5 is stored as 1 and the other fields still update.
- R8: Clearing bit 4 is accepted only if bit 3 is also 0 in the same write. Otherwise bit 4 is stored as 1.
- R9: A wake-up pulse sets bits 5, 4 and 3 of the power register to 1 at the next clock edge. This also applies in the cycle of a commit, where the wake-up takes priority.
- R10: The key addresses 0x1, 0x2, 0x4 and 0x5 always read 0, as do unmapped addresses. Bus reads do not break a key sequence. Read data is 0 while the read enable is low.
- R11: Peripheral register bit 2 is the SPI/I2C enable, bit 5 the UART enable and bit 8 the PWM enable, with 1 meaning powered. All other bits are stored as 0. For example, a committed value of 0x4 enables SPI/I2C and powers down the UART and PWM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Combinational read data |
| wake | input | 1 | Wake-up event pulse |
| xtal_en | output | 1 | Crystal circuitry enable |
| pll_en | output | 1 | PLL enable |
| periph_en | output | 1 | Peripheral domain enable |
| core_en | output | 1 | Core enable |
| core_div | output | 3 | Core clock divide select |
| spi_en | output | 1 | SPI/I2C enable |
| uart_en | output | 1 | UART enable |
| pwm_en | output | 1 | PWM enable |

## Verification
The bench uses the default parameters, ADDR_W=4 and DATA_W=16. The 16-bit data path reaches the PWM enable at bit 8 and the upper bits that must be masked. The 4-bit address lets random writes land on the unmapped addresses 6 and 7, so these act as stray writes that must abort a sequence. Random runs mix complete key sequences with stray key values and wake pulses. Every result is compared with a history-window model of the last two writes.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  localparam logic [3:0] A_PWR      = 4'h0;
  localparam logic [3:0] A_PWR_PRE  = 4'h1;
  localparam logic [3:0] A_PWR_POST = 4'h2;
  localparam logic [3:0] A_PER      = 4'h3;
  localparam logic [3:0] A_PER_PRE  = 4'h4;
  localparam logic [3:0] A_PER_POST = 4'h5;

  localparam logic [7:0] K_PWR_PRE  = 8'h01;
  localparam logic [7:0] K_PWR_POST = 8'hF4;
  localparam logic [7:0] K_PER_PRE  = 8'h76;
  localparam logic [7:0] K_PER_POST = 8'hB1;

  localparam int PWR_W    = 8;
  localparam int SPI_BIT  = 2;
  localparam int UART_BIT = 5;
  localparam int PWM_BIT  = 8;
  localparam int PER_W    = PWM_BIT + 1;

  localparam logic [PWR_W-1:0] PWR_RST = 8'h7B;
  localparam logic [PER_W-1:0] PER_MASK =
    PER_W'((1 << SPI_BIT) | (1 << UART_BIT) | (1 << PWM_BIT));

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_ARM_PWR, SEQ_PEND_PWR, SEQ_ARM_PER, SEQ_PEND_PER
  } seq_e;

  // Apply the domain shutdown ordering to a written power value.
  function automatic logic [PWR_W-1:0] legalize_pwr(logic [PWR_W-1:0] w);
    logic [PWR_W-1:0] r;
    r = {1'b0, w[6:0]};
    if (!w[5] && (w[4] || w[3])) r[5] = 1'b1;
    if (!w[4] && w[3])           r[4] = 1'b1;
    return r;
  endfunction

  // Core clock in kHz for a divide select value.
  function automatic int unsigned core_khz(logic [2:0] sel);
    return 32'd10240 >> sel;
  endfunction

endpackage

// File: rtl/pwr_key_seq.sv
module pwr_key_seq
  import pwr_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pwr_commit,
  output logic              per_commit,
  output logic [DATA_W-1:0] pend_val
);

  seq_e st_q, st_d;
  logic [DATA_W-1:0] pend_q;

  logic hit_pwr_pre, hit_pwr_post, hit_per_pre, hit_per_post;
  logic to_pwr, to_per;

  assign hit_pwr_pre  = we && addr == ADDR_W'(A_PWR_PRE)  && wdata == DATA_W'(K_PWR_PRE);
  assign hit_pwr_post = we && addr == ADDR_W'(A_PWR_POST) && wdata == DATA_W'(K_PWR_POST);
  assign hit_per_pre  = we && addr == ADDR_W'(A_PER_PRE)  && wdata == DATA_W'(K_PER_PRE);
  assign hit_per_post = we && addr == ADDR_W'(A_PER_POST) && wdata == DATA_W'(K_PER_POST);
  assign to_pwr = we && st_q == SEQ_ARM_PWR && addr == ADDR_W'(A_PWR);
  assign to_per = we && st_q == SEQ_ARM_PER && addr == ADDR_W'(A_PER);

  assign pwr_commit = st_q == SEQ_PEND_PWR && hit_pwr_post;
  assign per_commit = st_q == SEQ_PEND_PER && hit_per_post;
  assign pend_val   = pend_q;

  always_comb begin
    st_d = st_q;
    if (we) begin
      if (hit_pwr_pre)      st_d = SEQ_ARM_PWR;
      else if (hit_per_pre) st_d = SEQ_ARM_PER;
      else if (to_pwr)      st_d = SEQ_PEND_PWR;
      else if (to_per)      st_d = SEQ_PEND_PER;
      else                  st_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pend_q <= '0;
    end else begin
      st_q <= st_d;
      if (to_pwr || to_per) pend_q <= wdata;
    end
  end

  assert_one_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_commit, per_commit}));

  assert_read_keeps_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> st_q == $past(st_q));

endmodule

// File: rtl/pwr_main_reg.sv
module pwr_main_reg
  import pwr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [PWR_W-1:0] val,
  input  logic             wake,
  output logic [PWR_W-1:0] q
);

  logic [PWR_W-1:0] d;

  always_comb begin
    d = q;
    if (commit) d = legalize_pwr(val);
    if (wake)   d[5:3] = 3'b111;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= PWR_RST;
    else        q <= d;
  end

  assert_keyed_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(commit || wake));

  assert_pll_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !q[5] |-> (!q[4] && !q[3]));

  assert_per_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !q[4] |-> !q[3]);

  assert_wake_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> q[5:3] == 3'b111);

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !q[7]);

endmodule

// File: rtl/pwr_per_reg.sv
module pwr_per_reg
  import pwr_ctl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(PER_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= MASK;
    else if (commit) q <= val & MASK;
  end

  assert_per_keyed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(commit));

  assert_per_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == '0);

endmodule

// File: rtl/pwr_key_regs.sv
module pwr_key_regs
  import pwr_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake,
  output logic              xtal_en,
  output logic              pll_en,
  output logic              periph_en,
  output logic              core_en,
  output logic [2:0]        core_div,
  output logic              spi_en,
  output logic              uart_en,
  output logic              pwm_en
);

  logic              pwr_commit, per_commit;
  logic [DATA_W-1:0] pend_val;
  logic [PWR_W-1:0]  pwr_q;
  logic [DATA_W-1:0] per_q;

  pwr_key_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pwr_commit(pwr_commit), .per_commit(per_commit), .pend_val(pend_val)
  );

  pwr_main_reg u_pwr (
    .clk(clk), .rst_n(rst_n), .commit(pwr_commit), .val(pend_val[PWR_W-1:0]),
    .wake(wake), .q(pwr_q)
  );

  pwr_per_reg #(.DATA_W(DATA_W)) u_per (
    .clk(clk), .rst_n(rst_n), .commit(per_commit), .val(pend_val), .q(per_q)
  );

  assign xtal_en   = pwr_q[6];
  assign pll_en    = pwr_q[5];
  assign periph_en = pwr_q[4];
  assign core_en   = pwr_q[3];
  assign core_div  = pwr_q[2:0];
  assign spi_en    = per_q[SPI_BIT];
  assign uart_en   = per_q[UART_BIT];
  assign pwm_en    = per_q[PWM_BIT];

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == ADDR_W'(A_PWR))      bus_rdata = DATA_W'(pwr_q);
      else if (bus_addr == ADDR_W'(A_PER)) bus_rdata = per_q;
    end
  end

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == '0);

endmodule

// File: tb/pwr_key_regs_test.sv
`timescale 1ns/1ps
module pwr_key_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, wake = 1'b0;
  logic [15:0] bus_rdata;
  logic        xtal_en, pll_en, periph_en, core_en, spi_en, uart_en, pwm_en;
  logic [2:0]  core_div;

  int checks = 0, fails = 0;
  logic [7:0]  m_pwr;
  logic [15:0] m_per;
  logic [3:0]  h1a, h2a;
  logic [15:0] h1d, h2d;

  always #4 clk = ~clk;

  pwr_key_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .wake(wake),
    .xtal_en(xtal_en), .pll_en(pll_en), .periph_en(periph_en), .core_en(core_en),
    .core_div(core_div), .spi_en(spi_en), .uart_en(uart_en), .pwm_en(pwm_en)
  );

  function automatic logic [7:0] exp_pwr(logic [15:0] w);
    logic [7:0] v;
    v = w[7:0] & 8'h7F;
    if (v[5] == 1'b0 && (v & 8'h18) != 0) v = v | 8'h20;
    if (v[4] == 1'b0 && v[3] == 1'b1)    v = v | 8'h10;
    return v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: a commit needs the two previous writes to be the unlock key and the target.
  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic wk = 1'b0);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; wake = wk;
    @(negedge clk);
    bus_we = 1'b0; wake = 1'b0;
    if (a == 4'h2 && d == 16'h00F4 && h1a == 4'h0 && h2a == 4'h1 && h2d == 16'h0001)
      m_pwr = exp_pwr(h1d);
    if (a == 4'h5 && d == 16'h00B1 && h1a == 4'h3 && h2a == 4'h4 && h2d == 16'h0076)
      m_per = h1d & 16'h0124;
    if (wk) m_pwr = m_pwr | 8'h38;
    h2a = h1a; h2d = h1d; h1a = a; h1d = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a; bus_re = 1'b1;
    #2 v = bus_rdata;
    bus_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    m_pwr = m_pwr | 8'h38;
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    rd(4'h0, v); chk({req, " pwr read"}, v, {8'h00, m_pwr});
    rd(4'h3, v); chk({req, " per read"}, v, m_per);
    chk({req, " pwr pins"}, {9'd0, xtal_en, pll_en, periph_en, core_en, core_div},
        {9'd0, m_pwr[6], m_pwr[5], m_pwr[4], m_pwr[3], m_pwr[2:0]});
    chk({req, " per pins"}, {13'd0, pwm_en, uart_en, spi_en},
        {13'd0, m_per[8], m_per[5], m_per[2]});
  endtask

  task automatic keyed_pwr(input logic [15:0] d, input string req);
    wr(4'h1, 16'h0001); wr(4'h0, d); wr(4'h2, 16'h00F4);
    check_all(req);
  endtask

  task automatic keyed_per(input logic [15:0] d, input string req);
    wr(4'h4, 16'h0076); wr(4'h3, d); wr(4'h5, 16'h00B1);
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    m_pwr = 8'h7B; m_per = 16'h0124;
    h1a = 4'hF; h2a = 4'hF; h1d = '0; h2d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and clock decode
    check_all("R1");
    chk("R1 div kHz", 16'(pwr_ctl_pkg::core_khz(core_div)), 16'd1280);

    // R2 keyed write, invisible before the commit key
    wr(4'h1, 16'h0001); wr(4'h0, 16'h0045);
    rd(4'h0, v); chk("R2 before commit", v, 16'h007B);
    wr(4'h2, 16'h00F4);
    check_all("R2");
    chk("R2 div kHz", 16'(pwr_ctl_pkg::core_khz(core_div)), 16'd320);

    // R3 missing unlock key
    wr(4'h0, 16'h007B); check_all("R3");

    // R4 wrong commit key, interruption after target, interruption after unlock
    wr(4'h1, 16'h0001); wr(4'h0, 16'h007B); wr(4'h2, 16'h0012); check_all("R4 wrong key");
    wr(4'h1, 16'h0001); wr(4'h0, 16'h007B); wr(4'h7, 16'h0000); wr(4'h2, 16'h00F4);
    check_all("R4 stray after");
    wr(4'h1, 16'h0001); wr(4'h6, 16'h0001); wr(4'h0, 16'h007B); wr(4'h2, 16'h00F4);
    check_all("R4 stray before");

    // R10 reads inside a sequence, key registers read zero
    wr(4'h1, 16'h0001);
    rd(4'h1, v); chk("R10 key read", v, 16'h0000);
    wr(4'h0, 16'h007B);
    rd(4'h2, v); chk("R10 key read", v, 16'h0000);
    rd(4'h5, v); chk("R10 key read", v, 16'h0000);
    wr(4'h2, 16'h00F4);
    check_all("R10");

    // R7 illegal PLL-only power-down, other fields still update
    keyed_pwr(16'h005C, "R7 pll only");
    keyed_pwr(16'h0050, "R7 pll with core off");
    // R8 peripheral down while core up, then legal combination
    keyed_pwr(16'h0068, "R8 illegal");
    keyed_pwr(16'h0066, "R8 legal");
    // R6 reserved bit
    keyed_pwr(16'h00FB, "R6");

    // R9 wake while powered down, and wake in the commit cycle
    keyed_pwr(16'h0002, "R9 all down");
    pulse_wake(); check_all("R9 wake");
    wr(4'h1, 16'h0001); wr(4'h0, 16'h0000); wr(4'h2, 16'h00F4, 1'b1);
    check_all("R9 same cycle");

    // R5 / R11 peripheral register
    keyed_per(16'h0004, "R11 spi only");
    wr(4'h3, 16'h0124); check_all("R5 unkeyed");
    wr(4'h4, 16'h0076); wr(4'h3, 16'h0124); wr(4'h5, 16'h00B0); check_all("R5 wrong key");
    keyed_per(16'hFFFF, "R11 mask");
    keyed_per(16'h0120, "R5 keyed");

    // Random mix of full sequences, stray writes and wake pulses (R2 R4 R5 R9)
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [15:0] rd16;
      op = $urandom_range(0, 9);
      rd16 = 16'($urandom);
      if (op < 3) begin
        wr(4'h1, 16'h0001); wr(4'h0, rd16); wr(4'h2, 16'h00F4);
      end else if (op < 5) begin
        wr(4'h4, 16'h0076); wr(4'h3, rd16); wr(4'h5, 16'h00B1);
      end else if (op == 5) begin
        pulse_wake();
      end else begin
        logic [3:0] a;
        logic [15:0] d;
        a = 4'($urandom_range(0, 7));
        case ($urandom_range(0, 4))
          0: d = 16'h0001;
          1: d = 16'h00F4;
          2: d = 16'h0076;
          3: d = 16'h00B1;
          default: d = rd16;
        endcase
        wr(a, d);
      end
      check_all("R4 random");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule